// File: doc/BRIEF.md
# Write-Protect Command Gate

This block filters decoded commands in a serial memory slave before they reach the program/erase engine. For each chip-select transaction, the opcode decoder reports one command class together with a completion strobe. The gate then decides whether that command may start (`cmd_accept`) or must be dropped (`cmd_ignore`). The decision depends on the level of the active-low write-protect pin at the moment the command completes.

While the pin is low, program and erase commands are dropped, and so are writes to the protect register. Commands that enable protection or lock sectors down still pass, as does every other class. A dropped command leaves the gate parked until chip-select goes high. The `preg_lock` output tells the protect-register logic when writes to that register are barred.

Top module: `wp_cmd_gate`

## Requirements
- R1: While `rst_n` is low, `cmd_accept`, `cmd_ignore` and `preg_lock` are 0 (asynchronously). Reset release is synchronised through two clock edges.
- R2: A transaction opens only on a high-to-low change of `cs_n` seen after reset. A `cmd_valid` outside an open transaction has no effect, and this includes `cs_n` held low through reset.
- R3: With `wp_n` high, every class is accepted. `cmd_accept` is high for exactly one cycle, after the edge that samples `cmd_valid`, and `cmd_ignore` stays 0.
- R4: With `wp_n` low, program (class 1) and erase (class 2) are dropped. `cmd_ignore` rises and `cmd_accept` stays 0.
- R5: With `wp_n` low, a protect-register write (class 3) is dropped in the same way.
- R6: With `wp_n` low, enable-protection (class 4), lockdown (class 5) and other (class 0; codes 6 and 7 also count as other) are accepted.
- R7: `cmd_ignore` stays high until `cs_n` is sampled high, and it is 0 after that edge. Only the first `cmd_valid` of a transaction is decided; later ones have no effect.
- R8: `wp_n` is sampled on the edge that takes `cmd_valid`. Later changes of `wp_n` do not alter that decision. If the sampled value was low, `preg_lock` stays high until the transaction closes.
- R9: `preg_lock` goes high one edge after `wp_n` is sampled low, whether or not a transaction is open. Outside a held transaction, it returns to 0 one edge after `wp_n` is sampled high.
- R10: A `cmd_valid` in the same cycle that `cs_n` is sampled high closes the transaction without a decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wp_n | input | 1 | Active-low write-protect pin level |
| cmd_valid | input | 1 | Command byte complete, class valid |
| cmd_class | input | 3 | Decoded command class |
| cmd_accept | output | 1 | One-cycle strobe: command may start |
| cmd_ignore | output | 1 | Command dropped; held until deselect |
| preg_lock | output | 1 | Protect-register writes barred |

## Verification
The hardest case to reach is a reset that lands in the middle of a dropped transaction while `cs_n` stays low. The bench asserts reset there, checks that the ignore flag clears at once, and releases reset with `cs_n` still low. It then proves that a command is not taken until `cs_n` goes high and falls again. A second awkward case is `wp_n` rising after a protected decision. The bench toggles the pin inside the transaction and watches `preg_lock` hold until deselect.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;
  localparam int CLS_W = 3;

  localparam logic [CLS_W-1:0] CLS_OTHER    = 3'd0;
  localparam logic [CLS_W-1:0] CLS_PROGRAM  = 3'd1;
  localparam logic [CLS_W-1:0] CLS_ERASE    = 3'd2;
  localparam logic [CLS_W-1:0] CLS_PREG_WR  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_PROT_EN  = 3'd4;
  localparam logic [CLS_W-1:0] CLS_LOCKDOWN = 3'd5;

  typedef enum logic [1:0] {
    GS_IDLE,
    GS_OPEN,
    GS_DONE,
    GS_DROP
  } gate_state_e;
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wp_cs_edge.sv
module wp_cs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_start
);
  logic cs_q;

  // Reset to "low" so a chip select held low through reset never opens a transaction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b0;
    else        cs_q <= cs_n;
  end

  assign cs_start = cs_q & ~cs_n;
endmodule

// File: rtl/wp_cmd_filter.sv
module wp_cmd_filter
  import wp_gate_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             wp_active,
  output logic             blocked
);
  logic guarded;

  always_comb begin
    unique case (cls)
      CLS_PROGRAM, CLS_ERASE, CLS_PREG_WR: guarded = 1'b1;
      default:                             guarded = 1'b0;
    endcase
  end

  assign blocked = wp_active & guarded;
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
  import wp_gate_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wp_n,
  input  logic             cmd_valid,
  input  logic [CLS_W-1:0] cmd_class,
  output logic             cmd_accept,
  output logic             cmd_ignore,
  output logic             preg_lock
);
  logic        rst_n_int;
  logic        cs_start;
  logic        blocked;
  gate_state_e state_q, state_d;
  logic        accept_q, accept_d;
  logic        held_q, held_d;
  logic        pin_lock_q;

  wp_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  wp_cs_edge cs_edge_i (
    .clk(clk), .rst_n(rst_n_int), .cs_n(cs_n), .cs_start(cs_start)
  );

  wp_cmd_filter filter_i (
    .cls(cmd_class), .wp_active(~wp_n), .blocked(blocked)
  );

  always_comb begin
    state_d  = state_q;
    accept_d = 1'b0;
    held_d   = held_q;
    unique case (state_q)
      GS_IDLE: if (cs_start) state_d = GS_OPEN;
      GS_OPEN: begin
        if (cs_n) begin
          state_d = GS_IDLE;
        end else if (cmd_valid) begin
          state_d  = blocked ? GS_DROP : GS_DONE;
          accept_d = ~blocked;
          held_d   = ~wp_n;
        end
      end
      GS_DONE, GS_DROP: if (cs_n) state_d = GS_IDLE;
      default: state_d = GS_IDLE;
    endcase
    if (state_d == GS_IDLE) held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q    <= GS_IDLE;
      accept_q   <= 1'b0;
      held_q     <= 1'b0;
      pin_lock_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      accept_q   <= accept_d;
      held_q     <= held_d;
      pin_lock_q <= ~wp_n;
    end
  end

  assign cmd_accept = accept_q;
  assign cmd_ignore = (state_q == GS_DROP);
  assign preg_lock  = pin_lock_q | held_q;

  // R3
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    cmd_accept |=> !cmd_accept);

  // R3
  accept_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    cmd_accept |-> ($past(cmd_valid) && !$past(cs_n)));

  // R4
  protected_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_valid && !wp_n && (cmd_class == CLS_PROGRAM || cmd_class == CLS_ERASE
                            || cmd_class == CLS_PREG_WR)) |=> !cmd_accept);

  // R7
  ignore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_ignore && !cs_n) |=> cmd_ignore);

  // R7
  ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    cs_n |=> !cmd_ignore);

  // R9
  pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !wp_n |=> preg_lock);

  // R3
  accept_ignore_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(cmd_accept && cmd_ignore));
endmodule

// File: tb/wp_cmd_gate_tb_top.sv
module wp_cmd_gate_tb_top;
  import wp_gate_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n, cs_n, wp_n, cmd_valid;
  logic [CLS_W-1:0] cmd_class;
  logic             cmd_accept, cmd_ignore, preg_lock;
  int               n_checks = 0;
  int               n_errors = 0;
  logic             acc_s, ign_s;

  always #4 clk = ~clk;

  wp_cmd_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_class(cmd_class),
    .cmd_accept(cmd_accept), .cmd_ignore(cmd_ignore), .preg_lock(preg_lock)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic open_txn();
    @(negedge clk);
    cs_n = 1'b0;
    step();
  endtask

  task automatic close_txn();
    @(negedge clk);
    cs_n      = 1'b1;
    cmd_valid = 1'b0;
    step();
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk);
    wp_n = v;
  endtask

  task automatic issue(input logic [CLS_W-1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_class = c;
    step();
    acc_s = cmd_accept;
    ign_s = cmd_ignore;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "accept in reset", cmd_accept, 1'b0);
    chk("R1", "ignore in reset", cmd_ignore, 1'b0);
    chk("R1", "lock in reset", preg_lock, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic test_unprotected();
    for (int c = 0; c < 8; c++) begin
      open_txn();
      issue(c[CLS_W-1:0]);
      chk("R3", $sformatf("accept cls %0d", c), acc_s, 1'b1);
      chk("R3", $sformatf("ignore cls %0d", c), ign_s, 1'b0);
      step();
      chk("R3", "accept is one pulse", cmd_accept, 1'b0);
      close_txn();
    end
  endtask

  task automatic test_protected();
    set_wp(1'b0);
    for (int c = 0; c < 6; c++) begin
      logic drop;
      drop = (c == 1) || (c == 2) || (c == 3);
      open_txn();
      issue(c[CLS_W-1:0]);
      if (c == 3) begin
        chk("R5", "preg write accept", acc_s, 1'b0);
        chk("R5", "preg write ignore", ign_s, 1'b1);
      end else if (drop) begin
        chk("R4", $sformatf("accept cls %0d", c), acc_s, 1'b0);
        chk("R4", $sformatf("ignore cls %0d", c), ign_s, 1'b1);
      end else begin
        chk("R6", $sformatf("accept cls %0d", c), acc_s, 1'b1);
        chk("R6", $sformatf("ignore cls %0d", c), ign_s, 1'b0);
      end
      close_txn();
    end
    set_wp(1'b1);
    step();
  endtask

  task automatic test_ignore_hold();
    set_wp(1'b0);
    open_txn();
    issue(CLS_ERASE);
    chk("R7", "ignore raised", ign_s, 1'b1);
    set_wp(1'b1);
    repeat (3) step();
    chk("R7", "ignore held", cmd_ignore, 1'b1);
    issue(CLS_OTHER);
    chk("R7", "second command not accepted", acc_s, 1'b0);
    chk("R7", "ignore still held", ign_s, 1'b1);
    close_txn();
    chk("R7", "ignore cleared on deselect", cmd_ignore, 1'b0);
  endtask

  task automatic test_sampling();
    open_txn();
    issue(CLS_PROGRAM);
    chk("R8", "accept with wp high", acc_s, 1'b1);
    set_wp(1'b0);
    step();
    chk("R8", "no late ignore", cmd_ignore, 1'b0);
    close_txn();
    set_wp(1'b1);
    step();
    set_wp(1'b0);
    step();
    open_txn();
    issue(CLS_PROT_EN);
    chk("R8", "prot-enable accepted", acc_s, 1'b1);
    set_wp(1'b1);
    repeat (2) step();
    chk("R8", "lock held after pin rises", preg_lock, 1'b1);
    close_txn();
    chk("R8", "lock released at deselect", preg_lock, 1'b0);
  endtask

  task automatic test_pin_lock();
    set_wp(1'b0);
    step();
    chk("R9", "lock follows pin low, idle", preg_lock, 1'b1);
    set_wp(1'b1);
    step();
    chk("R9", "lock follows pin high, idle", preg_lock, 1'b0);
  endtask

  task automatic test_no_txn();
    issue(CLS_PROGRAM);
    chk("R2", "no accept while deselected", acc_s, 1'b0);
    chk("R2", "no ignore while deselected", ign_s, 1'b0);
    set_wp(1'b0);
    open_txn();
    issue(CLS_PROGRAM);
    chk("R4", "drop before reset", ign_s, 1'b1);
    do_reset();
    set_wp(1'b1);
    step();
    issue(CLS_OTHER);
    chk("R2", "no accept with cs low through reset", acc_s, 1'b0);
    close_txn();
    open_txn();
    issue(CLS_OTHER);
    chk("R2", "accept after fresh falling cs", acc_s, 1'b1);
    close_txn();
  endtask

  task automatic test_cs_race();
    open_txn();
    @(negedge clk);
    cs_n      = 1'b1;
    cmd_valid = 1'b1;
    cmd_class = CLS_PROGRAM;
    step();
    chk("R10", "no accept on closing edge", cmd_accept, 1'b0);
    chk("R10", "no ignore on closing edge", cmd_ignore, 1'b0);
    @(negedge clk);
    cmd_valid = 1'b0;
    open_txn();
    issue(CLS_PROGRAM);
    chk("R10", "next transaction works", acc_s, 1'b1);
    close_txn();
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1; cmd_valid = 1'b0; cmd_class = '0;
    repeat (3) step();
    chk("R1", "accept at reset", cmd_accept, 1'b0);
    chk("R1", "ignore at reset", cmd_ignore, 1'b0);
    chk("R1", "lock at reset", preg_lock, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    test_unprotected();
    test_protected();
    test_ignore_hold();
    test_sampling();
    test_pin_lock();
    test_no_txn();
    test_cs_race();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule